// File: doc/BRIEF.md
# Finite Queued Pulse Sequencer

The block plays out a finite train of pulses whose shapes come from a queue. Software or an upstream engine writes shape entries into a small FIFO. Each entry carries two lengths: a low time and a high time, both counted in source ticks. When the sequencer is started with a pulse count, it takes one entry per pulse. For each entry it drives the output low for the low time, then high for the high time. The next entry follows on the very next tick, with no gap. Every pulse may therefore have a different shape.

The source tick is a clock enable: the phase counters move only on cycles where it is high. A run ends when the requested number of pulses has been produced. At that point the output rests low and a completion flag rises. If the queue runs dry before the count is reached, the sequencer parks with its output low and raises an underflow flag. A write that arrives while the queue is full is discarded and reported on a one-cycle flag. No fixed pulse registers exist: all shape information for a run comes from the queue.

Top module: `pulse_seq_top`

## Requirements
- R1: Each entry produces exactly one pulse. The output is low for the entry's low length in ticks, then high for its high length in ticks. The first low phase begins with the clock edge that samples `start`.
- R2: Consecutive entries join with no gap. On the tick that ends one entry's high phase, the next entry's low phase begins, and the next entry is read from the queue in that same cycle.
- R3: After the number of pulses given by `pulse_count` at start, the output stays low. From the edge that ends the last high phase, `done` is 1 until the next accepted start.
- R4: A start with `pulse_count` equal to 0 sets `done` one cycle later. It reads no entry, so the queue contents are kept for a later run.
- R5: If an entry is needed while the queue is empty, `underflow` becomes 1 and the output stays low until the next accepted start. This covers the first entry at start as well as any later one.
- R6: The phase counters advance only on cycles with `tick` high. With `tick` low, the output does not change.
- R7: A length field of 0 is treated as one tick.
- R8: `wr_full` is 1 when the queue holds DEPTH entries (default 4). A write while the queue is full is discarded, and `wr_drop` is 1 for the single cycle after it.
- R9: A start is accepted only when no run is in progress. A start while pulses are being produced has no effect on the output or on the count.
- R10: After reset, `pulse_out`, `done`, `underflow`, `wr_full` and `wr_drop` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one shape entry |
| wr_low_len | input | LEN_W (16) | Low phase length in ticks |
| wr_high_len | input | LEN_W (16) | High phase length in ticks |
| wr_full | output | 1 | Queue holds DEPTH entries |
| wr_drop | output | 1 | Previous-cycle write was discarded |
| tick | input | 1 | Source tick enable |
| start | input | 1 | Begin a run (ignored while running) |
| pulse_count | input | CNT_W (16) | Number of pulses for the run, sampled with start |
| pulse_out | output | 1 | Generated pulse train |
| done | output | 1 | Run completed |
| underflow | output | 1 | Queue ran dry during a run |

## Verification
The state register that drives `pulse_out`, `done` and `underflow` is loaded on the edge that samples `start` or an active `tick`. Each of these outputs is therefore due one clock after its cause. `wr_drop` is due one clock after the rejected write. The scoreboard exploits this. Expected per-cycle triples of output, done and underflow are queued at the falling edge on which `start` is driven, and the monitor pops one each cycle, one nanosecond after every rising edge. When ticks are held off, the bench expects one fewer low sample after ticks resume, because the entry was already loaded during the stall.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    parameter int LEN_W = 16;
    parameter int CNT_W = 16;

    typedef struct packed {
        logic [LEN_W-1:0] low_len;
        logic [LEN_W-1:0] high_len;
    } shape_t;

    localparam int SHAPE_W = $bits(shape_t);

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_LOW   = 3'd1,
        SQ_HIGH  = 3'd2,
        SQ_DONE  = 3'd3,
        SQ_DRY   = 3'd4
    } seq_state_t;

    function automatic logic [LEN_W-1:0] at_least_one(input logic [LEN_W-1:0] v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

endpackage

// File: rtl/pseq_fifo.sv
module pseq_fifo #(
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  pseq_pkg::shape_t wdata,
    input  logic             pop,
    output pseq_pkg::shape_t rdata,
    output logic             empty,
    output logic             full,
    output logic             dropped
);
    pseq_pkg::shape_t mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            fill    <= '0;
            dropped <= 1'b0;
        end else begin
            dropped <= push && full;
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

endmodule

// File: rtl/pseq_engine.sv
module pseq_engine #(
    parameter int LEN_W = pseq_pkg::LEN_W,
    parameter int CNT_W = pseq_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic             q_empty,
    input  pseq_pkg::shape_t q_head,
    output logic             q_pop,
    output logic             pulse_out,
    output logic             done,
    output logic             underflow
);
    import pseq_pkg::*;

    seq_state_t       state;
    logic [LEN_W-1:0] phase_left;
    logic [LEN_W-1:0] high_len_q;
    logic [CNT_W-1:0] pulses_left;

    logic can_start, accept_start, phase_end, last_pulse, want_next, need_entry;

    assign can_start    = (state == SQ_IDLE) || (state == SQ_DONE) || (state == SQ_DRY);
    assign accept_start = can_start && start;
    assign phase_end    = tick && (phase_left == LEN_W'(1));
    assign last_pulse   = (pulses_left == CNT_W'(1));
    assign want_next    = (state == SQ_HIGH) && phase_end && !last_pulse;
    assign need_entry   = (accept_start && (start_count != '0)) || want_next;
    assign q_pop        = need_entry && !q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_IDLE;
            phase_left  <= '0;
            high_len_q  <= '0;
            pulses_left <= '0;
        end else if (accept_start) begin
            pulses_left <= start_count;
            if (start_count == '0) begin
                state <= SQ_DONE;
            end else if (q_empty) begin
                state <= SQ_DRY;
            end else begin
                state      <= SQ_LOW;
                phase_left <= at_least_one(q_head.low_len);
                high_len_q <= at_least_one(q_head.high_len);
            end
        end else begin
            case (state)
                SQ_LOW: begin
                    if (phase_end) begin
                        state      <= SQ_HIGH;
                        phase_left <= high_len_q;
                    end else if (tick) begin
                        phase_left <= phase_left - LEN_W'(1);
                    end
                end
                SQ_HIGH: begin
                    if (phase_end) begin
                        if (last_pulse) begin
                            state <= SQ_DONE;
                        end else if (q_empty) begin
                            state <= SQ_DRY;
                        end else begin
                            state       <= SQ_LOW;
                            phase_left  <= at_least_one(q_head.low_len);
                            high_len_q  <= at_least_one(q_head.high_len);
                            pulses_left <= pulses_left - CNT_W'(1);
                        end
                    end else if (tick) begin
                        phase_left <= phase_left - LEN_W'(1);
                    end
                end
                default: state <= state;
            endcase
        end
    end

    assign pulse_out = (state == SQ_HIGH);
    assign done      = (state == SQ_DONE);
    assign underflow = (state == SQ_DRY);

endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top #(
    parameter int DEPTH = 4,
    parameter int LEN_W = pseq_pkg::LEN_W,
    parameter int CNT_W = pseq_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_low_len,
    input  logic [LEN_W-1:0] wr_high_len,
    output logic             wr_full,
    output logic             wr_drop,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] pulse_count,
    output logic             pulse_out,
    output logic             done,
    output logic             underflow
);
    import pseq_pkg::*;

    shape_t wr_shape, head;
    logic   q_empty, q_pop;

    assign wr_shape.low_len  = wr_low_len;
    assign wr_shape.high_len = wr_high_len;

    pseq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (wr_en),
        .wdata   (wr_shape),
        .pop     (q_pop),
        .rdata   (head),
        .empty   (q_empty),
        .full    (wr_full),
        .dropped (wr_drop)
    );

    pseq_engine #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start       (start),
        .start_count (pulse_count),
        .q_empty     (q_empty),
        .q_head      (head),
        .q_pop       (q_pop),
        .pulse_out   (pulse_out),
        .done        (done),
        .underflow   (underflow)
    );

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic wr_full,
    input logic wr_drop,
    input logic tick,
    input logic pulse_out,
    input logic done,
    input logic underflow
);
    // R5
    dry_low_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> !pulse_out);

    // R3
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pulse_out && !underflow));

    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pulse_out));

    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_full) |=> wr_drop);

    // R8
    drop_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_full) |=> !wr_drop);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!pulse_out && !done && !underflow && !wr_full && !wr_drop));

endmodule

bind pulse_seq_top pseq_chk u_pseq_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .wr_drop   (wr_drop),
    .tick      (tick),
    .pulse_out (pulse_out),
    .done      (done),
    .underflow (underflow)
);

// File: tb/test_pulse_seq_top.sv
`timescale 1ns/1ps
module test_pulse_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_low_len = '0, wr_high_len = '0;
    logic        wr_full, wr_drop;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic [15:0] pulse_count = '0;
    logic        pulse_out, done, underflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [2:0] exp_q [$];
    string      tag_q [$];
    logic [2:0] e;
    string      t;

    always #2 clk = ~clk;

    pulse_seq_top i_pulse_seq_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_low_len(wr_low_len),
        .wr_high_len(wr_high_len), .wr_full(wr_full), .wr_drop(wr_drop),
        .tick(tick), .start(start), .pulse_count(pulse_count),
        .pulse_out(pulse_out), .done(done), .underflow(underflow)
    );

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {out,done,underflow} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: one expected item per cycle, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {pulse_out, done, underflow}, e);
        end
    end

    task automatic expect_n(input logic [2:0] v, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic expect_pulse(input int lo, input int hi, input string tag);
        expect_n(3'b000, eff(lo), tag);
        expect_n(3'b100, eff(hi), tag);
    endtask

    task automatic wr(input int lo, input int hi);
        wr_en = 1'b1; wr_low_len = 16'(lo); wr_high_len = 16'(hi);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go(input int cnt);
        start = 1'b1; pulse_count = 16'(cnt);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10", {pulse_out, done, underflow}, 3'b000);
        check("R10 full/drop", {1'b0, wr_full, wr_drop}, 3'b000);

        // R1 R7 single shapes incl. zero length, then done (R3)
        wr(2, 3); wr(0, 0);
        expect_pulse(2, 3, "R1");
        expect_pulse(0, 0, "R7");
        expect_n(3'b010, 3, "R3");
        go(2);
        drain();

        // R2 back to back with refill during run, R9 start ignored mid-run
        wr(2, 3); wr(1, 1); wr(3, 2); wr(0, 0);
        expect_pulse(2, 3, "R2");
        expect_pulse(1, 1, "R2");
        expect_pulse(3, 2, "R2");
        expect_pulse(0, 0, "R2");
        expect_pulse(2, 2, "R2");
        expect_pulse(1, 4, "R2");
        expect_n(3'b010, 3, "R3 count");
        go(6);
        repeat (8) @(negedge clk);
        wr(2, 2);
        start = 1'b1; pulse_count = 16'd1;   // R9: must be ignored
        @(negedge clk);
        start = 1'b0;
        wr(1, 4);
        drain();

        // R4 zero count keeps queue content
        wr(2, 2);
        expect_n(3'b010, 2, "R4");
        go(0);
        drain();
        expect_pulse(2, 2, "R4 kept");
        expect_n(3'b010, 2, "R4 kept");
        go(1);
        drain();

        // R5 underflow mid-run
        wr(1, 2); wr(2, 1);
        expect_pulse(1, 2, "R5");
        expect_pulse(2, 1, "R5");
        expect_n(3'b001, 4, "R5");
        go(3);
        drain();

        // R5 underflow at start with empty queue
        expect_n(3'b001, 3, "R5 empty");
        go(2);
        drain();

        // R8 full and drop
        wr(1, 1); wr(1, 1); wr(1, 1);
        check("R8 not full", {1'b0, wr_full, wr_drop}, 3'b000);
        wr(1, 1);
        check("R8 full", {1'b0, wr_full, wr_drop}, 3'b010);
        wr(5, 5);
        check("R8 drop", {1'b0, wr_full, wr_drop}, 3'b011);
        @(negedge clk);
        check("R8 drop one cycle", {1'b0, wr_full, wr_drop}, 3'b010);
        for (int k = 0; k < 4; k++) expect_pulse(1, 1, "R8");
        expect_n(3'b001, 3, "R8 dropped entry absent");
        go(5);
        drain();

        // R6 no ticks: nothing moves
        wr(3, 2);
        tick = 1'b0;
        go(1);
        for (int k = 0; k < 6; k++) begin
            check("R6 stall", {pulse_out, done, underflow}, 3'b000);
            @(negedge clk);
        end
        expect_n(3'b000, 2, "R6");
        expect_n(3'b100, 2, "R6");
        expect_n(3'b010, 2, "R6");
        tick = 1'b1;
        drain();

        finish_up();
    end
endmodule